// File: doc/BRIEF.md
# PI-Regulated Sawtooth PWM Gate Generator

This block closes a voltage loop for one leg of a power converter. Once per switching period it receives a signed measurement of the regulated voltage, together with a valid strobe. It forms the difference between the commanded and the measured value and runs a proportional-integral law on that difference. The clipped result becomes the on-time of a single gate signal. The on-time counts in ticks of a free-running sawtooth counter. With the default parameters the period is 334 ticks, which gives 15 kHz at a 0.2 µs tick.

A new on-time only takes effect when the sawtooth wraps, so a pulse is never cut short or stretched in the middle of a period. The same module, with the same parameters, serves both the DC bus loop and the midpoint loop, one instance each. The gains are unsigned fixed point values with `FRAC` fractional bits.

The gate sequencer is a small state machine with three states:
- `GS_IDLE`: no measurement has been received since reset, and the gate stays low.
- `GS_ARMED`: a duty value has been computed and is waiting for the next wrap.
- `GS_RUN`: the gate follows the latched duty.

The state machine has three transitions:
- IDLE→ARMED: a duty value becomes available outside a wrap cycle.
- IDLE→RUN: a duty value is available in a wrap cycle.
- ARMED→RUN: a wrap occurs.

RUN is held until reset.

Top module: `pi_pwm_gen`

## Requirements
- R1: The sawtooth counter starts at 0 after reset, increments by one each clock, and returns to 0 in the clock after it reaches `CNT_MAX` (333 by default), so one period is `CNT_MAX+1` clocks.
- R2: In `GS_RUN` the gate is high exactly while the counter is strictly below the active duty value, so each period begins with one contiguous high pulse whose length equals the duty value.
- R3: On a strobe, the error is setpoint minus measurement, the integrator candidate is the stored integral plus that error, and the raw duty is (kp·error + ki·candidate) arithmetically shifted right by `FRAC` bits (floor).
- R4: The raw duty is clipped to the range 0 to `CNT_MAX+1`. A duty of 0 keeps the gate low for the whole period, and `CNT_MAX+1` (334) keeps it high for the whole period. A raw value of exactly 334 is not clipped.
- R5: When the raw duty is clipped, the stored integral keeps its old value. Otherwise it takes the candidate value.
- R6: Setpoint, measurement and gain inputs have no effect unless the strobe is high. Between strobes, the gate pattern repeats the previous period.
- R7: The active duty value changes only on the wrap clock edge, and it takes the most recent computed value. A strobe taken in the wrap cycle itself therefore first shows in the period after the next one.
- R8: Synchronous reset clears the counter and the integral and forces the gate low. The gate stays low until the first wrap that follows the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter tick clock |
| rst | input | 1 | Synchronous reset, active high |
| setpoint_i | input | DATA_W | Commanded voltage, signed |
| meas_i | input | DATA_W | Measured voltage, signed |
| meas_valid_i | input | 1 | One-clock strobe: new measurement present |
| kp_i | input | GAIN_W | Proportional gain, unsigned, FRAC fractional bits |
| ki_i | input | GAIN_W | Integral gain, unsigned, FRAC fractional bits |
| gate_o | output | 1 | Switch gate drive |

## Verification
The hardest case to reach is a strobe that lands in the wrap cycle itself. At that edge the active duty is latched from the previous value while the new value is being computed, so the new value must skip a full period. The bench keeps its own model of the counter phase and fires a strobe at tick 333. It then expects the old pulse width in the following period and the new one in the period after that. Anti-windup is reached by first driving the loop hard into the upper clip with a large integral gain, then reversing the error. A correct integrator lands on a mid-range duty, while a wound-up one would stay pinned at full on.

// File: rtl/pipwm_pkg.sv
package pipwm_pkg;
    typedef enum logic [1:0] {
        GS_IDLE  = 2'd0,
        GS_ARMED = 2'd1,
        GS_RUN   = 2'd2
    } gate_state_e;
endpackage

// File: rtl/pwm_sawtooth.sv
module pwm_sawtooth #(
    parameter int CNT_MAX = 333,
    parameter int CNT_W   = $clog2(CNT_MAX + 2)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == TOP)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (cnt_q == TOP);

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TOP);
    assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == TOP) |=> (cnt_q == '0));
    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/pi_duty_calc.sv
module pi_duty_calc #(
    parameter int DATA_W   = 16,
    parameter int GAIN_W   = 12,
    parameter int FRAC     = 8,
    parameter int ACC_W    = 32,
    parameter int CNT_W    = 9,
    parameter int DUTY_MAX = 334
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] setpoint_i,
    input  logic [DATA_W-1:0] meas_i,
    input  logic              valid_i,
    input  logic [GAIN_W-1:0] kp_i,
    input  logic [GAIN_W-1:0] ki_i,
    output logic [CNT_W-1:0]  duty_o,
    output logic              have_o
);
    localparam int ERR_W = DATA_W + 1;
    localparam int SUM_W = ACC_W + GAIN_W + 2;
    localparam logic signed [SUM_W-1:0] LIMIT_HI = SUM_W'(DUTY_MAX);

    logic signed [ACC_W-1:0] integ_q;
    logic [CNT_W-1:0]        duty_q;
    logic                    have_q;

    logic signed [ERR_W-1:0] err;
    logic signed [ACC_W-1:0] integ_cand;
    logic signed [SUM_W-1:0] p_term, i_term, raw;
    logic                    clip_lo, clip_hi, clipped;
    logic [CNT_W-1:0]        duty_nxt;

    always_comb begin
        err        = $signed({setpoint_i[DATA_W-1], setpoint_i})
                   - $signed({meas_i[DATA_W-1], meas_i});
        integ_cand = integ_q + ACC_W'(err);
        p_term     = SUM_W'(err) * SUM_W'($signed({1'b0, kp_i}));
        i_term     = SUM_W'(integ_cand) * SUM_W'($signed({1'b0, ki_i}));
        raw        = (p_term + i_term) >>> FRAC;
        clip_lo    = (raw < 0);
        clip_hi    = (raw > LIMIT_HI);
        clipped    = clip_lo || clip_hi;
        if (clip_lo)
            duty_nxt = '0;
        else if (clip_hi)
            duty_nxt = CNT_W'(DUTY_MAX);
        else
            duty_nxt = raw[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q <= '0;
            duty_q  <= '0;
            have_q  <= 1'b0;
        end else if (valid_i) begin
            duty_q <= duty_nxt;
            have_q <= 1'b1;
            if (!clipped)
                integ_q <= integ_cand;
        end
    end

    assign duty_o = duty_q;
    assign have_o = have_q;

    assert_duty_bound_R4: assert property (@(posedge clk) disable iff (rst)
        duty_q <= CNT_W'(DUTY_MAX));
    assert_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(integ_q) && $stable(duty_q)));
    assert_antiwindup_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && clipped) |=> $stable(integ_q));
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm #(
    parameter int CNT_W    = 9,
    parameter int DUTY_MAX = 334
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             have_i,
    output logic             gate_o
);
    import pipwm_pkg::*;

    gate_state_e      state_q, state_d;
    logic [CNT_W-1:0] duty_act_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE: begin
                if (have_i && wrap_i)
                    state_d = GS_RUN;
                else if (have_i)
                    state_d = GS_ARMED;
            end
            GS_ARMED: begin
                if (wrap_i)
                    state_d = GS_RUN;
            end
            GS_RUN:  state_d = GS_RUN;
            default: state_d = GS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= GS_IDLE;
            duty_act_q <= '0;
        end else begin
            state_q <= state_d;
            if (wrap_i && have_i)
                duty_act_q <= duty_i;
        end
    end

    always_comb begin
        gate_o = (state_q == GS_RUN) && (cnt_i < duty_act_q);
    end

    assert_duty_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !wrap_i |=> $stable(duty_act_q));
    assert_run_needs_data_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q != GS_IDLE) |-> have_i);
    assert_full_on_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == GS_RUN && duty_act_q == CNT_W'(DUTY_MAX)) |-> gate_o);
endmodule

// File: rtl/pi_pwm_gen.sv
module pi_pwm_gen #(
    parameter int DATA_W  = 16,
    parameter int GAIN_W  = 12,
    parameter int FRAC    = 8,
    parameter int ACC_W   = 32,
    parameter int CNT_MAX = 333
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] setpoint_i,
    input  logic [DATA_W-1:0] meas_i,
    input  logic              meas_valid_i,
    input  logic [GAIN_W-1:0] kp_i,
    input  logic [GAIN_W-1:0] ki_i,
    output logic              gate_o
);
    localparam int DUTY_MAX = CNT_MAX + 1;
    localparam int CNT_W    = $clog2(DUTY_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic [CNT_W-1:0] duty;
    logic             have;

    pwm_sawtooth #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_saw (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    pi_duty_calc #(
        .DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC(FRAC),
        .ACC_W(ACC_W), .CNT_W(CNT_W), .DUTY_MAX(DUTY_MAX)
    ) u_pi (
        .clk        (clk),
        .rst        (rst),
        .setpoint_i (setpoint_i),
        .meas_i     (meas_i),
        .valid_i    (meas_valid_i),
        .kp_i       (kp_i),
        .ki_i       (ki_i),
        .duty_o     (duty),
        .have_o     (have)
    );

    gate_fsm #(.CNT_W(CNT_W), .DUTY_MAX(DUTY_MAX)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .cnt_i  (cnt),
        .wrap_i (wrap),
        .duty_i (duty),
        .have_i (have),
        .gate_o (gate_o)
    );
endmodule

// File: tb/pi_pwm_gen_bench.sv
`timescale 1ns/1ps
module pi_pwm_gen_bench;
    localparam int PER = 334;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] setpoint = '0;
    logic [15:0] meas = '0;
    logic        valid = 1'b0;
    logic [11:0] kp = '0;
    logic [11:0] ki = '0;
    logic        gate;

    always #10 clk = ~clk;

    pi_pwm_gen u_pi_pwm_gen (
        .clk(clk), .rst(rst), .setpoint_i(setpoint), .meas_i(meas),
        .meas_valid_i(valid), .kp_i(kp), .ki_i(ki), .gate_o(gate)
    );

    typedef struct { int target; int duty; string tag; } exp_t;
    exp_t q[$];

    int checks = 0;
    int fails  = 0;
    int mpos = 0;
    bit live = 1'b0;
    int wnum = 0;
    int last_target = 2;
    int last_duty = 0;
    longint integ = 0;
    bit finished = 1'b0;

    // bench view of the tick phase, from R1
    always @(posedge clk) begin
        live <= !rst;
        if (rst) mpos <= 0;
        else     mpos <= (mpos == PER - 1) ? 0 : mpos + 1;
    end

    // monitor: R2 pulse shape per period against popped expectations
    int    cur_exp = 0;
    string cur_tag = "R8";
    bit    in_win = 1'b0;
    int    highs = 0;
    int    bad_pos = -1;
    always @(negedge clk) begin
        if (live && mpos == 0) begin
            wnum = wnum + 1;
            while (q.size() > 0 && q[0].target <= wnum) begin
                exp_t e;
                e = q.pop_front();
                cur_exp = e.duty;
                cur_tag = e.tag;
            end
            in_win = 1'b1; highs = 0; bad_pos = -1;
        end
        if (in_win && live) begin
            if (gate) highs++;
            if (gate != (mpos < cur_exp) && bad_pos < 0) bad_pos = mpos;
            if (mpos == PER - 1) begin
                checks++;
                if (bad_pos >= 0) begin
                    fails++;
                    $display("FAIL %s (R1 R2) period %0d: high ticks actual %0d expected %0d, first bad tick %0d",
                             cur_tag, wnum, highs, cur_exp, bad_pos);
                end
                in_win = 1'b0;
            end
        end
    end

    // driver: strobe one measurement at a given tick, push expected duty
    task automatic apply(input int sp, input int ms, input int at, input string tag);
        longint err, inew, u;
        int d;
        @(negedge clk);
        while (wnum < last_target - 1) @(negedge clk);
        while (!(live && wnum > 0 && mpos == at)) @(negedge clk);
        err  = longint'(sp) - longint'(ms);
        inew = integ + err;
        u    = (longint'(kp) * err + longint'(ki) * inew) >>> 8;
        if (u < 0)            d = 0;
        else if (u > PER)     d = PER;
        else begin d = int'(u); integ = inew; end
        if (at == PER - 1) begin
            q.push_back('{target: wnum + 1, duty: last_duty, tag: "R7"});
            last_target = wnum + 2;
        end else begin
            last_target = wnum + 1;
        end
        q.push_back('{target: last_target, duty: d, tag: tag});
        last_duty = d;
        setpoint = 16'(sp); meas = 16'(ms); valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
    endtask

    // R6: change inputs without a strobe; pattern must repeat
    task automatic idle_windows(input int n, input int sp, input int ms);
        setpoint = 16'(sp); meas = 16'(ms); kp = 12'd4095; ki = 12'd4095;
        for (int k = 1; k <= n; k++)
            q.push_back('{target: last_target + k, duty: last_duty, tag: "R6"});
        last_target = last_target + n;
        while (wnum <= last_target) @(negedge clk);
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (gate !== 1'b0) begin
                fails++;
                $display("FAIL R8 gate during reset: actual %b expected 0", gate);
            end
        end
        rst = 1'b0;
        kp = 12'd256; ki = 12'd0;
        apply(1000, 850, 100, "R3");      // 150
        apply(100, 300, 100, "R4");       // clipped low: 0
        apply(2000, 0, 100, "R4");        // clipped high: 334
        idle_windows(2, 0, 5000);
        kp = 12'd0; ki = 12'd64;
        apply(300, 100, 100, "R3");       // integral 350 -> 87
        apply(300, 100, 100, "R3");       // integral 550 -> 137
        kp = 12'd0; ki = 12'd256;
        apply(20000, 0, 100, "R4");       // clipped, integral held at 550
        apply(0, 300, 100, "R5");         // 250 only with anti-windup
        apply(0, 100, PER - 1, "R7");     // taken in wrap cycle -> 150 two periods on
        kp = 12'd384; ki = 12'd16;
        apply(-500, -600, 100, "R3");     // signed inputs
        kp = 12'd256; ki = 12'd0;
        apply(134, -200, 100, "R4");      // raw exactly 334, not clipped
        apply(-50, -50, 200, "R4");       // zero error, duty 0
        while (wnum <= last_target) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule